// File: doc/BRIEF.md
# Pointer-Register Indirect Address Unit

This unit forms the effective data-memory address for the load, store, push and pop operations of a small 8-bit processor. It also keeps the pointer values up to date. It holds three 16-bit address pointers (X, Y, Z) and a 16-bit stack pointer. A decoded request selects one addressing mode. The unit returns the address, a read/write qualifier and a pointer write-back, which tells the register file the pointer's new value.

Each request is accepted only when the unit is idle. The unit then stays busy for the rest of the operation. Data-memory operations occupy two cycles and a program-memory fetch occupies three. Pointer side effects follow a fixed order. An update that precedes the access (pre-decrement, pop) is reported in the same cycle as the address. An update that follows the access (post-increment, push) is reported one cycle later. A separate load port lets the register file write any pointer directly.

Top module: `ptr_addr_unit`

## Requirements
- R1: Mode code 0 (plain) with pointer select 0=X, 1=Y or 2=Z drives the selected pointer's value on `addr` with `addr_valid` high in the cycle after acceptance, and produces no write-back.
- R2: Mode code 1 (post-increment) addresses at the current pointer value. In the second cycle after acceptance it pulses `wb_en` with `wb_val` = pointer + 1 and `wb_sel` = the selected pointer, and the pointer takes that value.
- R3: Mode code 2 (pre-decrement) addresses at pointer − 1. In the same cycle as the address it pulses `wb_en` with that value, and the pointer takes it.
- R4: Mode code 3 (displacement) on Y or Z addresses at pointer + zero-extended `req_disp` (0 to 63) and produces no write-back.
- R5: Mode 3 with X, or any of modes 0–3 with pointer select 3, raises `illegal` for one cycle. It produces no `addr_valid` and no write-back, and leaves every pointer unchanged.
- R6: Mode code 4 (direct) drives `req_direct` on `addr`, with `mem_we` equal to `req_store`.
- R7: Mode code 5 (push) writes at the stack pointer and afterwards reports stack pointer − 1, with `wb_sel` = 3. Mode code 6 (pop) reads at stack pointer + 1 and reports that value in the same cycle. For all other data modes, `mem_we` follows `req_store`.
- R8: Mode code 7 (program fetch) addresses at Z, with `prog_rd` high and `addr_valid` low. It keeps `busy` high for two cycles after acceptance.
- R9: After any accepted request, `busy` is high for the next cycle (two for mode 7). Requests presented while `busy` is high are ignored.
- R10: All pointer and displacement arithmetic wraps modulo 2^16.
- R11: After reset, all outputs are low, X, Y and Z are 0, and the stack pointer equals `SP_RESET`.
- R12: `ld_en` writes `ld_val` into the pointer chosen by `ld_sel` (0=X, 1=Y, 2=Z, 3=stack) at the clock edge. If a pointer write-back lands on the same pointer at the same edge, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Direct address |
| req_store | input | 1 | 1 = store, 0 = load |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_val | input | 16 | Value to load |
| busy | output | 1 | Operation in progress |
| addr | output | 16 | Effective address |
| addr_valid | output | 1 | Data-memory access this cycle |
| mem_we | output | 1 | Data-memory write |
| prog_rd | output | 1 | Program-memory read this cycle |
| illegal | output | 1 | Rejected mode/pointer combination |
| wb_en | output | 1 | Pointer write-back pulse |
| wb_sel | output | 2 | Pointer being written back |
| wb_val | output | 16 | New pointer value |

## Verification
The assertions watch the following on every cycle:
- the timing relation between acceptance and `busy`;
- whether a write-back comes early or late for each mode;
- the pre-decrement address matching its write-back;
- the post-increment write-back being the address plus one;
- the direct address passing through;
- the read/write direction for push and pop;
- the silencing of every output on an illegal request.

Only the bench's scenarios can show the rest:
- the actual pointer contents carried from one request to the next;
- the displacement sum;
- wrap-around of the pointers;
- the reset value of the stack pointer;
- the priority of a write-back over a simultaneous load;
- that a request made during `busy` leaves no trace.

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
  parameter int AW = 16,
  parameter int QW = 6,
  parameter logic [AW-1:0] SP_RESET = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [1:0]    req_ptr,
  input  logic [QW-1:0] req_disp,
  input  logic [AW-1:0] req_direct,
  input  logic          req_store,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_val,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          mem_we,
  output logic          prog_rd,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  localparam logic [2:0] M_PLAIN = 3'd0, M_POSTI = 3'd1, M_PRED = 3'd2, M_DISP = 3'd3,
                         M_DIR = 3'd4, M_PUSH = 3'd5, M_POP = 3'd6, M_PROG = 3'd7;
  localparam logic [1:0] SEL_X = 2'd0, SEL_Z = 2'd2, SEL_SP = 2'd3;

  logic [AW-1:0] ptr_q [4];
  logic [1:0]    cnt_q;
  logic          pend_en;
  logic [1:0]    pend_sel;
  logic [AW-1:0] pend_val;

  logic [1:0]    sel;
  logic [AW-1:0] cur, ea, nv;
  logic          early, late, we, bad, accept;

  assign sel = (req_mode == M_PUSH || req_mode == M_POP) ? SEL_SP :
               (req_mode == M_PROG) ? SEL_Z : req_ptr;
  assign cur = ptr_q[sel];
  assign bad = (req_mode <= M_DISP && req_ptr == SEL_SP) ||
               (req_mode == M_DISP && req_ptr == SEL_X);
  assign accept = req_valid && (cnt_q == 2'd0);
  assign busy = (cnt_q != 2'd0);

  always_comb begin
    ea = cur;
    nv = cur;
    early = 1'b0;
    late = 1'b0;
    we = req_store;
    case (req_mode)
      M_POSTI: begin nv = cur + AW'(1); late = 1'b1; end
      M_PRED:  begin nv = cur - AW'(1); ea = nv; early = 1'b1; end
      M_DISP:  ea = cur + {{(AW-QW){1'b0}}, req_disp};
      M_DIR:   ea = req_direct;
      M_PUSH:  begin nv = cur - AW'(1); late = 1'b1; we = 1'b1; end
      M_POP:   begin nv = cur + AW'(1); ea = nv; early = 1'b1; we = 1'b0; end
      M_PROG:  we = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
      ptr_q[2] <= '0;
      ptr_q[3] <= SP_RESET;
      cnt_q <= 2'd0;
      addr <= '0;
      addr_valid <= 1'b0;
      mem_we <= 1'b0;
      prog_rd <= 1'b0;
      illegal <= 1'b0;
      wb_en <= 1'b0;
      wb_sel <= 2'd0;
      wb_val <= '0;
      pend_en <= 1'b0;
      pend_sel <= 2'd0;
      pend_val <= '0;
    end else begin
      if (ld_en) ptr_q[ld_sel] <= ld_val;
      if (accept) begin
        cnt_q <= (req_mode == M_PROG) ? 2'd2 : 2'd1;
        addr <= ea;
        addr_valid <= !bad && (req_mode != M_PROG);
        mem_we <= !bad && we;
        prog_rd <= (req_mode == M_PROG);
        illegal <= bad;
        wb_en <= early && !bad;
        wb_sel <= sel;
        wb_val <= nv;
        pend_en <= late && !bad;
        pend_sel <= sel;
        pend_val <= nv;
        if (early && !bad) ptr_q[sel] <= nv;
      end else begin
        if (cnt_q != 2'd0) cnt_q <= cnt_q - 2'd1;
        addr_valid <= 1'b0;
        mem_we <= 1'b0;
        prog_rd <= 1'b0;
        illegal <= 1'b0;
        wb_en <= pend_en;
        wb_sel <= pend_sel;
        wb_val <= pend_val;
        pend_en <= 1'b0;
        if (pend_en) ptr_q[pend_sel] <= pend_val;
      end
    end
  end
endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic [1:0]    req_ptr,
  input logic [AW-1:0] req_direct,
  input logic          req_store,
  input logic          busy,
  input logic [AW-1:0] addr,
  input logic          addr_valid,
  input logic          mem_we,
  input logic          prog_rd,
  input logic          illegal,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic [AW-1:0] wb_val
);
  logic acc, ptr_ok;
  assign acc = req_valid && !busy;
  assign ptr_ok = (req_ptr != 2'd3);

  assert_plain_nowb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd0 && ptr_ok |=> addr_valid && !wb_en ##1 !wb_en);
  assert_postinc_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd1 && ptr_ok |=> !wb_en ##1 (wb_en && wb_val == $past(addr) + AW'(1)));
  assert_predec_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd2 && ptr_ok |=> wb_en && addr_valid && wb_val == addr);
  assert_disp_nowb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd3 |=> !wb_en ##1 !wb_en);
  assert_illegal_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !addr_valid && !wb_en && !mem_we);
  assert_direct_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd4 |=> addr_valid && addr == $past(req_direct) && mem_we == $past(req_store));
  assert_push_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd5 |=> mem_we && addr_valid && !wb_en ##1 (wb_en && wb_sel == 2'd3));
  assert_pop_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd6 |=> !mem_we && wb_en && wb_sel == 2'd3 && wb_val == addr);
  assert_prog_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 3'd7 |=> prog_rd && !addr_valid && busy ##1 busy);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  assert_access_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || prog_rd || illegal) |-> busy);
endmodule

bind ptr_addr_unit ptr_addr_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .req_ptr(req_ptr), .req_direct(req_direct), .req_store(req_store),
  .busy(busy), .addr(addr), .addr_valid(addr_valid), .mem_we(mem_we),
  .prog_rd(prog_rd), .illegal(illegal), .wb_en(wb_en), .wb_sel(wb_sel),
  .wb_val(wb_val)
);

// File: tb/sim_ptr_addr_unit.sv
module sim_ptr_addr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, ld_en = 1'b0;
  logic [2:0] req_mode = '0;
  logic [1:0] req_ptr = '0, ld_sel = '0;
  logic [5:0] req_disp = '0;
  logic [15:0] req_direct = '0, ld_val = '0;
  logic busy, addr_valid, mem_we, prog_rd, illegal, wb_en;
  logic [1:0] wb_sel;
  logic [15:0] addr, wb_val;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ptr_addr_unit u0 (.*);

  // {mode, ptr, disp, direct, store, exp_addr, exp_we, wb_kind(0 none,1 early,2 late), exp_wb_val}
  localparam int NV = 13;
  localparam logic [62:0] VEC [NV] = '{
    {3'd0, 2'd0, 6'd0,  16'h0000, 1'b0, 16'h1000, 1'b0, 2'd0, 16'h0000},
    {3'd1, 2'd0, 6'd0,  16'h0000, 1'b1, 16'h1000, 1'b1, 2'd2, 16'h1001},
    {3'd0, 2'd0, 6'd0,  16'h0000, 1'b0, 16'h1001, 1'b0, 2'd0, 16'h0000},
    {3'd2, 2'd1, 6'd0,  16'h0000, 1'b0, 16'h1FFF, 1'b0, 2'd1, 16'h1FFF},
    {3'd3, 2'd1, 6'd63, 16'h0000, 1'b1, 16'h203E, 1'b1, 2'd0, 16'h0000},
    {3'd1, 2'd2, 6'd0,  16'h0000, 1'b0, 16'hFFFF, 1'b0, 2'd2, 16'h0000}, // R10 wrap up
    {3'd2, 2'd2, 6'd0,  16'h0000, 1'b1, 16'hFFFF, 1'b1, 2'd1, 16'hFFFF}, // R10 wrap down
    {3'd3, 2'd2, 6'd0,  16'h0000, 1'b0, 16'hFFFF, 1'b0, 2'd0, 16'h0000},
    {3'd4, 2'd0, 6'd0,  16'hABCD, 1'b1, 16'hABCD, 1'b1, 2'd0, 16'h0000},
    {3'd5, 2'd0, 6'd0,  16'h0000, 1'b0, 16'h0800, 1'b1, 2'd2, 16'h07FF},
    {3'd6, 2'd0, 6'd0,  16'h0000, 1'b1, 16'h0800, 1'b0, 2'd1, 16'h0800},
    {3'd2, 2'd0, 6'd0,  16'h0000, 1'b0, 16'h1000, 1'b0, 2'd1, 16'h1000},
    {3'd3, 2'd2, 6'd1,  16'h0000, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0000}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] p, input logic [5:0] q,
                       input logic [15:0] d, input logic s);
    req_valid = 1'b1; req_mode = m; req_ptr = p; req_disp = q; req_direct = d; req_store = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] v);
    ld_en = 1'b1; ld_sel = s; ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "busy at reset", 32'(busy), 0);
    chk("R11", "outputs at reset", {addr_valid, mem_we, prog_rd, illegal, wb_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle after reset", {busy, addr_valid, wb_en}, 0);
    issue(3'd0, 2'd1, 6'd0, 16'h0, 1'b0);
    chk("R11", "Y reset value", 32'(addr), 0);
    @(negedge clk);
    issue(3'd5, 2'd0, 6'd0, 16'h0, 1'b1);
    chk("R11", "stack reset value", 32'(addr), 32'h0FFF);
    @(negedge clk);
    chk("R11", "push wb after reset", 32'(wb_val), 32'h0FFE);

    load(2'd0, 16'h1000);
    load(2'd1, 16'h2000);
    load(2'd2, 16'hFFFF);
    load(2'd3, 16'h0800);
    issue(3'd0, 2'd3, 6'd0, 16'h0, 1'b0);
    chk("R12", "load of stack, pointer select 3 illegal", 32'(illegal), 1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      string t;
      logic [1:0] esel;
      v = VEC[i];
      t = tag_of(v[62:60]);
      esel = (v[62:60] == 3'd5 || v[62:60] == 3'd6) ? 2'd3 : v[59:58];
      issue(v[62:60], v[59:58], v[57:52], v[51:36], v[35]);
      chk(t, "addr", 32'(addr), 32'(v[34:19]));
      chk(t, "addr_valid/busy", {addr_valid, busy}, 2'b11);
      chk(t, "mem_we", 32'(mem_we), 32'(v[18]));
      chk(t, "early wb_en", 32'(wb_en), 32'(v[17:16] == 2'd1));
      if (v[17:16] == 2'd1) chk(t, "early wb", {wb_sel, wb_val}, {esel, v[15:0]});
      @(negedge clk);
      chk(t, "late wb_en", 32'(wb_en), 32'(v[17:16] == 2'd2));
      if (v[17:16] == 2'd2) chk(t, "late wb", {wb_sel, wb_val}, {esel, v[15:0]});
      chk(t, "busy released", 32'(busy), 0);
    end

    // R10 displacement sum wraps
    load(2'd1, 16'hFFFF);
    issue(3'd3, 2'd1, 6'd63, 16'h0, 1'b0);
    chk("R10", "disp wrap addr", 32'(addr), 32'h003E);
    @(negedge clk);

    // R5 displacement on X rejected
    issue(3'd3, 2'd0, 6'd5, 16'h0, 1'b1);
    chk("R5", "illegal/addr_valid/wb/we", {illegal, addr_valid, wb_en, mem_we}, 4'b1000);
    @(negedge clk);
    chk("R5", "no late wb", {illegal, wb_en}, 0);
    issue(3'd1, 2'd3, 6'd0, 16'h0, 1'b0);
    chk("R5", "sel 3 postinc illegal", {illegal, addr_valid, wb_en}, 3'b100);
    @(negedge clk);
    chk("R5", "sel 3 no late wb", 32'(wb_en), 0);
    issue(3'd0, 2'd0, 6'd0, 16'h0, 1'b0);
    chk("R5", "X unchanged", 32'(addr), 32'h1000);
    @(negedge clk);

    // R8 program fetch through Z (Z = 0xFFFF)
    issue(3'd7, 2'd0, 6'd0, 16'h0, 1'b1);
    chk("R8", "prog addr", 32'(addr), 32'hFFFF);
    chk("R8", "prog_rd/addr_valid/we/busy", {prog_rd, addr_valid, mem_we, busy}, 4'b1001);
    @(negedge clk);
    chk("R8", "second busy cycle", {busy, prog_rd}, 2'b10);
    @(negedge clk);
    chk("R8", "released", 32'(busy), 0);

    // R9 request during busy is ignored
    req_valid = 1'b1; req_mode = 3'd0; req_ptr = 2'd0; req_store = 1'b0;
    @(negedge clk);
    req_mode = 3'd4; req_direct = 16'h1234;
    chk("R9", "busy after accept", 32'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "busy-time request ignored", {busy, addr_valid}, 0);
    @(negedge clk);
    chk("R9", "still idle", {busy, addr_valid}, 0);

    // R12 write-back beats a simultaneous load
    issue(3'd1, 2'd0, 6'd0, 16'h0, 1'b0);
    ld_en = 1'b1; ld_sel = 2'd0; ld_val = 16'h5555;
    @(negedge clk);
    ld_en = 1'b0;
    issue(3'd0, 2'd0, 6'd0, 16'h0, 1'b0);
    chk("R12", "wb wins over load", 32'(addr), 32'h1001);
    @(negedge clk);
    load(2'd0, 16'h4242);
    issue(3'd0, 2'd0, 6'd0, 16'h0, 1'b0);
    chk("R12", "plain load", 32'(addr), 32'h4242);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule